// File: doc/BRIEF.md
# Skewed-Stream Matrix-Vector Multiplier

This block multiplies an N-by-N signed matrix by an N-element signed vector and returns the N products one by one. It uses a row of 2N-1 identical cells that all step together. In each cell a vector element arrives from the left and moves on to the right. A matrix element arrives from above. A partial sum arrives from the right, and the cell passes `left*top + right` on to its left neighbour. The cells hold no accumulator. The product is correct only because every operand reaches the right cell on the right step.

A sequencer sits around the cell row. When `start` is accepted, it captures the matrix and vector from the input buses. It then feeds the vector into the leftmost cell, one element on every even step, with zeros in between. Each cell's matrix element is chosen from the step count, so the matrix arrives transposed and skewed one diagonal per step. Every slot outside the active wavefront carries zero. Results leave the leftmost cell on alternate steps, and each is marked with a one-cycle `y_valid` pulse.

Top module: `skew_mv_array`

## Requirements
- R1: While `rst_n` is low, `busy` and `y_valid` are low and `y_data` is zero, even if `start` is high.
- R2: The worked case uses matrix rows (1,3,-4), (1,1,-2), (-1,-2,5) and vector (1,5,2). It yields 8, 2, -1 in that order.
- R3: Count the clock edge that accepts `start` as edge 0. `y_valid` is high after edges 2N-1+2i, for i = 0..N-1, and low after every other edge of the run. The i-th pulse carries the result of matrix row i.
- R4: Each result is the exact signed dot product of row i with the vector. The matrix bus holds element (i,j) at bits [(i*N+j)*DW +: DW], the vector bus holds element j at bits [j*DW +: DW], and both use DW-bit two's complement. `y_data` is OW = 2*DW+clog2(N)+1 bits wide and is two's complement.
- R5: `busy` rises on the edge that accepts `start`. It falls on the edge that delivers the last result, which is edge 4N-3.
- R6: A `start` pulse while `busy` is high is ignored. The run keeps its timing and its results.
- R7: The operands are captured on the accepting edge. Later changes on the matrix or vector bus do not affect the running product.
- R8: A new `start` is accepted in the cycle right after `busy` falls. Its results do not depend on the previous run.
- R9: Extreme operand values, all -128 or a mix of -128 and 127 when DW=8, produce exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all cells step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product; accepted only while idle |
| mat_in | input | N*N*DW | Matrix, element (i,j) at bits [(i*N+j)*DW +: DW] |
| vec_in | input | N*DW | Vector, element j at bits [j*DW +: DW] |
| busy | output | 1 | High while a product is in flight |
| y_valid | output | 1 | One-cycle pulse marking a result on `y_data` |
| y_data | output | OW | Signed result, row order |

## Verification
The worked case tests the skew against known numbers. An identity matrix tests whether each vector element meets its own row and column, which a skew error of one step would break. Random matrices compared with a dot product in the bench catch sign and width faults. All-negative and mixed full-scale operands test the output width. A stray `start` combined with changed operand buses mid-run shows whether capture and the idle-only acceptance hold. Runs started straight after `busy` falls show whether anything is left over from the previous run.

// File: rtl/skew_mv_array.sv
`timescale 1ns/1ps
module skew_mv_array #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int OW = 2*DW + $clog2(N) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N*N*DW-1:0]     mat_in,
  input  logic [N*DW-1:0]       vec_in,
  output logic                  busy,
  output logic                  y_valid,
  output logic [OW-1:0]         y_data
);
  localparam int M     = 2*N - 1;
  localparam int FIRST = 2*N - 2;
  localparam int LAST  = 4*N - 4;
  localparam int KW    = $clog2(4*N);

  logic [N*N*DW-1:0] mat_q;
  logic [N*DW-1:0]   vec_q;
  logic [KW-1:0]     k;
  int                kk;
  logic              go;

  assign kk = int'(k);
  assign go = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      k       <= '0;
      mat_q   <= '0;
      vec_q   <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= busy && (kk >= FIRST) && !k[0];
      if (go) begin
        busy  <= 1'b1;
        k     <= '0;
        mat_q <= mat_in;
        vec_q <= vec_in;
      end else if (busy) begin
        if (kk == LAST) busy <= 1'b0;
        k <= k + 1'b1;
      end
    end
  end

  int                 vj;
  logic signed [DW-1:0] xin;
  assign vj  = kk / 2;
  assign xin = (busy && !k[0] && vj < N) ? $signed(vec_q[(vj < N ? vj : 0)*DW +: DW]) : '0;

  logic signed [DW-1:0] xr  [M];
  logic signed [OW-1:0] sr  [M];
  logic signed [DW-1:0] lin [M];
  logic signed [OW-1:0] rin [M];
  logic signed [DW-1:0] top [M];

  for (genvar c = 0; c < M; c++) begin : g_cell
    int   s_c, r_c, j_c, idx_c;
    logic hit;
    logic signed [2*DW-1:0] prod;
    logic signed [DW-1:0]   xq;
    logic signed [OW-1:0]   sq;

    assign s_c   = kk + c;
    assign r_c   = s_c / 2 - (N - 1);
    assign j_c   = (kk - c) / 2;
    assign hit   = busy && (s_c % 2 == 0) && (kk >= c) && (r_c >= 0) && (r_c < N) && (j_c < N);
    assign idx_c = hit ? (r_c*N + j_c) : 0;
    assign top[c] = hit ? $signed(mat_q[idx_c*DW +: DW]) : '0;

    if (c == 0) begin : g_lend
      assign lin[c] = xin;
    end else begin : g_lmid
      assign lin[c] = xr[c-1];
    end
    if (c == M-1) begin : g_rend
      assign rin[c] = '0;
    end else begin : g_rmid
      assign rin[c] = sr[c+1];
    end

    assign prod = lin[c] * top[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xq <= '0;
        sq <= '0;
      end else if (go) begin
        xq <= '0;
        sq <= '0;
      end else begin
        xq <= lin[c];
        sq <= {{(OW-2*DW){prod[2*DW-1]}}, prod} + rin[c];
      end
    end

    assign xr[c] = xq;
    assign sr[c] = sq;
  end

  assign y_data = sr[0];
endmodule

module skew_mv_array_chk #(
  parameter int N = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic y_valid
);
  int   seen;
  logic was_rst;

  always_ff @(posedge clk) was_rst <= !rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen <= 0;
    else if (start && !busy)  seen <= 0;
    else if (y_valid)         seen <= seen + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) (was_rst && !rst_n) |-> (!busy && !y_valid));

  // R3
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) y_valid |=> !y_valid);

  // R3
  valid_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (busy ? (seen < N-1) : (seen == N-1)));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> y_valid);
endmodule

bind skew_mv_array skew_mv_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .y_valid(y_valid)
);

// File: tb/skew_mv_array_bench.sv
`timescale 1ns/1ps
module skew_mv_array_bench;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int OW = 2*DW + $clog2(N) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*N*DW-1:0] mat_in = '0;
  logic [N*DW-1:0]   vec_in = '0;
  logic              busy, y_valid;
  logic [OW-1:0]     y_data;

  int total = 0;
  int bad   = 0;
  int A [N][N];
  int X [N];

  always #2 clk = ~clk;

  skew_mv_array #(.N(N), .DW(DW)) u_skew_mv_array (
    .clk(clk), .rst_n(rst_n), .start(start), .mat_in(mat_in), .vec_in(vec_in),
    .busy(busy), .y_valid(y_valid), .y_data(y_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pack();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) mat_in[(i*N+j)*DW +: DW] = DW'(A[i][j]);
      vec_in[i*DW +: DW] = DW'(X[i]);
    end
  endtask

  task automatic scramble();
    for (int i = 0; i < N*N; i++) mat_in[i*DW +: DW] = DW'($urandom_range(0, 255));
    for (int i = 0; i < N; i++)   vec_in[i*DW +: DW] = DW'($urandom_range(0, 255));
  endtask

  task automatic run(input string req, input bit poke);
    longint e [N];
    bool_dummy: begin end
    for (int i = 0; i < N; i++) begin
      e[i] = 0;
      for (int j = 0; j < N; j++) e[i] += longint'(A[i][j]) * longint'(X[j]);
    end
    @(negedge clk);
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {req, " R5 busy after start"}, longint'(busy), 1);
    for (int cyc = 1; cyc <= 4*N-3; cyc++) begin
      bit expv;
      @(negedge clk);
      expv = (cyc >= 2*N-1) && ((cyc - (2*N-1)) % 2 == 0);
      chk(y_valid === expv, {req, " R3 valid timing"}, longint'(y_valid), longint'(expv));
      if (expv)
        chk(longint'($signed(y_data)) == e[(cyc-(2*N-1))/2], {req, " R4 result"},
            longint'($signed(y_data)), e[(cyc-(2*N-1))/2]);
      if (cyc >= 4*N-4)
        chk(busy === (cyc < 4*N-3), {req, " R5 busy end"}, longint'(busy), longint'(cyc < 4*N-3));
      if (poke && cyc == 2) begin
        start = 1'b1;
        scramble();
      end
      if (poke && cyc == 3) start = 1'b0;
    end
  endtask

  task automatic t_reset();
    start = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0,    "R1 busy in reset",    longint'(busy), 0);
    chk(y_valid === 1'b0, "R1 valid in reset",   longint'(y_valid), 0);
    chk(y_data === '0,    "R1 data in reset",    longint'(y_data), 0);
    start = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_example();
    int m [N][N] = '{'{1, 3, -4}, '{1, 1, -2}, '{-1, -2, 5}};
    A = m;
    X = '{1, 5, 2};
    chk((A[0][0]*X[0] + A[0][1]*X[1] + A[0][2]*X[2]) == 8, "R2 model row0", 0, 8);
    run("R2", 1'b0);
  endtask

  task automatic t_identity();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) A[i][j] = (i == j) ? 1 : 0;
      X[i] = 17 * (i + 1) - 40;
    end
    run("R4 identity", 1'b0);
  endtask

  task automatic t_random();
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) A[i][j] = int'($urandom_range(0, 255)) - 128;
        X[i] = int'($urandom_range(0, 255)) - 128;
      end
      run("R4 R8 random", 1'b0);
    end
  endtask

  task automatic t_extreme();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) A[i][j] = -128;
      X[i] = -128;
    end
    run("R9 all min", 1'b0);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) A[i][j] = 127;
      X[i] = -128;
    end
    run("R9 mixed", 1'b0);
  endtask

  task automatic t_poke();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) A[i][j] = (i + 1) * (j - 1) * 9;
      X[i] = 30 - 25 * i;
    end
    run("R6 R7 poke", 1'b1);
    @(negedge clk);
    chk(busy === 1'b0, "R6 no restart", longint'(busy), 0);
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_identity();
    t_random();
    t_extreme();
    t_poke();
    t_example();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule